// File: doc/BRIEF.md
# Previous-Element Stream Aligner

This block takes a stream of 32-bit words cut into frames of a fixed length and, for every input position, presents the word that stood just before it in the same frame. The first word out of every frame is a placeholder of all ones (the value -1), the next ones are the frame's words in arrival order, and the frame's final word never leaves the block. A frame of 0,1,...,9 with the default length of ten therefore leaves as -1,0,1,...,8.

Inside, two stages run back to back through a small FIFO. The first stage consumes every input word and forwards all but the last word of each frame. The second stage inserts the placeholder at the start of each frame without reading its FIFO, then forwards the remaining words. Both edges use a valid/ready handshake. The second stage stays silent until the FIFO first holds data, so its periodic count begins from a known point and the placeholder cannot be misplaced behind the first data word at start-up.

Top module: `prev_elem_aligner`

## Requirements
- R1: While reset is held and right after it, `outValid` is 0 and `inReady` is 1.
- R2: Before the first input word has been accepted, `outValid` stays 0 however long `outReady` is held high.
- R3: The first word out of each frame is the placeholder, 0xFFFFFFFF, and is emitted before the frame's first data word.
- R4: After the placeholder, input positions 0 to N-2 of the frame (N = `FRAME_LEN`, default 10) leave in arrival order with their values unchanged.
- R5: Input position N-1 of each frame is accepted and discarded; `inReady` is 1 at that position even when the FIFO is full.
- R6: While `outValid` is 1 and `outReady` is 0, the next cycle keeps `outValid` at 1 and `outData` unchanged; counters advance only on completed handshakes.
- R7: At positions 0 to N-2, `inReady` is 0 while the `FIFO_DEPTH` (default 8) entry FIFO is full, and no word is lost or duplicated.
- R8: Frame after frame, with gaps on the input and stalls on the output, the output stays the placeholder followed by N-1 forwarded words per frame.
- R9: Once started, the placeholder of the next frame is emitted as soon as the previous frame's last forwarded word has left, with no new input present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Block accepts the input word this cycle |
| inData | input | DATA_W | Input word |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Consumer takes the output word this cycle |
| outData | output | DATA_W | Output word (placeholder or forwarded word) |

## Verification
The hardest case to reach from the ports is the last position of a frame arriving while the FIFO is completely full, since normally the output side drains the FIFO well before that. The bench holds `outReady` low to fill the FIFO, then opens it for exactly one cycle so that one word leaves, sends one more word so the FIFO is full again with the drop position next, and then checks `inReady` before and after that dropped word. Start-up ordering is reached by idling with `outReady` high before any input, and the unprompted placeholder by draining everything and checking that the trailing placeholder still appears.

// File: rtl/prev_align_pkg.sv
package prev_align_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic push;       // write the input word into the FIFO
    logic pop;        // retire the FIFO head word to the output
    logic insertSel;  // output carries the placeholder instead of the head word
  } strobe_t;

  function automatic int cntWidth(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pa_fifo.sv
module pa_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == FULL_CNT);
  assign empty = (fill == '0);
  assign head  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R7: a write never lands on a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R4: a forwarded word always comes from a stored entry
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import prev_align_pkg::*;
#(
  parameter int FRAME_LEN = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  input  logic    outReady,
  input  logic    fifoFull,
  input  logic    fifoEmpty,
  output strobe_t stb
);
  localparam int CNT_W = cntWidth(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] dropCnt;
  logic [CNT_W-1:0] insCnt;
  logic             waitFirst;
  logic             dropPos, inFire, outFire, atStart;

  function automatic logic [CNT_W-1:0] wrapInc(input logic [CNT_W-1:0] c);
    return (c == LAST_POS) ? '0 : c + 1'b1;
  endfunction

  // Dropping stage: the last position never needs FIFO space.
  always_comb begin
    dropPos = (dropCnt == LAST_POS);
    inReady = dropPos || !fifoFull;
    inFire  = inValid && inReady;
  end

  // Inserting stage: valid and data choice come from the same count value.
  always_comb begin
    atStart       = (insCnt == '0);
    outValid      = !waitFirst && (atStart || !fifoEmpty);
    outFire       = outValid && outReady;
    stb.push      = inFire && !dropPos;
    stb.pop       = outFire && !atStart;
    stb.insertSel = atStart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dropCnt <= '0;
    end else if (inFire) begin
      dropCnt <= wrapInc(dropCnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waitFirst <= 1'b1;
      insCnt    <= '0;
    end else if (waitFirst) begin
      insCnt <= '0;
      if (!fifoEmpty) waitFirst <= 1'b0;
    end else if (outFire) begin
      insCnt <= wrapInc(insCnt);
    end
  end

  // R2: nothing leaves while no data has ever reached the FIFO
  p_silent_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (waitFirst && fifoEmpty) |=> !outValid);

  // R5: the drop position is always accepted
  p_drop_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dropCnt == LAST_POS) |-> inReady);

  // R6: a stalled output stays offered
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

  // R9: once started, a frame start offers the placeholder unconditionally
  p_placeholder_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!waitFirst && insCnt == '0) |-> outValid);

endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import prev_align_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam logic [DATA_W-1:0] PLACEHOLDER = '1;

  logic [DATA_W-1:0] headWord;

  pa_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) uLink (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stb.push),
    .wrData(inData),
    .pop   (stb.pop),
    .head  (headWord),
    .full  (fifoFull),
    .empty (fifoEmpty)
  );

  assign outData = stb.insertSel ? PLACEHOLDER : headWord;

endmodule

// File: rtl/prev_elem_aligner.sv
module prev_elem_aligner
  import prev_align_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FRAME_LEN  = 10,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  strobe_t stb;
  logic    fifoFull, fifoEmpty;

  pa_ctrl #(
    .FRAME_LEN(FRAME_LEN)
  ) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty),
    .stb      (stb)
  );

  pa_datapath #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .inData   (inData),
    .outData  (outData),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty)
  );

  // R6: a stalled output word does not change
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/prev_elem_aligner_test.sv
module prev_elem_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int FRAME_LEN  = 10;
  localparam int FIFO_DEPTH = 8;
  localparam logic [DATA_W-1:0] PH = '1;

  logic clk = 0, rst_n = 0;
  logic inValid = 0, outReady = 0;
  logic [DATA_W-1:0] inData = '0;
  logic inReady, outValid;
  logic [DATA_W-1:0] outData;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] expQ[$];
  int  pos = 0;
  bit  started = 0;
  bit  bpMode = 0;
  bit  readyLevel = 0;
  int  gapMax = 0;
  bit  prevStall = 0;
  logic [DATA_W-1:0] prevData = '0;

  prev_elem_aligner #(
    .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .FIFO_DEPTH(FIFO_DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output ready driver: steady level or random stalls.
  initial forever begin
    @(posedge clk); #1;
    outReady = bpMode ? (($urandom % 4) != 0) : readyLevel;
  end

  // Monitor / scoreboard, sampling at the falling edge.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prevStall) begin
        // R6: stalled word stays valid and stable
        check(outValid && outData == prevData, "R6", outData, prevData);
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R4 unexpected output", outData, '0);
        end else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          check(outData == e, (e == PH) ? "R3" : "R4/R8", outData, e);
        end
      end
    end
  end

  // Driver: offers one word, returns after it is accepted.
  task automatic sendWord(input logic [DATA_W-1:0] v);
    bit acc;
    int gap;
    gap = (gapMax > 0) ? int'($urandom % (gapMax + 1)) : 0;
    repeat (gap) begin @(posedge clk); #1; end
    inValid = 1; inData = v;
    do begin
      @(negedge clk); acc = inReady;
      @(posedge clk); #1;
    end while (!acc);
    inValid = 0;
    if (!started) begin expQ.push_back(PH); started = 1; end
    if (pos != FRAME_LEN - 1) expQ.push_back(v);
    if (pos == FRAME_LEN - 2) expQ.push_back(PH);
    pos = (pos == FRAME_LEN - 1) ? 0 : pos + 1;
  endtask

  task automatic waitDrain();
    int t = 0;
    while (expQ.size() != 0 && t < 5000) begin @(posedge clk); t++; end
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 0, "R1 outValid", {31'b0, outValid}, '0);
    check(inReady == 1, "R1 inReady", {31'b0, inReady}, 1);
    @(posedge clk); #1 rst_n = 1;

    // R2: idle with ready high before any input
    readyLevel = 1;
    begin
      bit seen = 0;
      repeat (20) begin @(negedge clk); if (outValid) seen = 1; end
      check(!seen, "R2 idle start", {31'b0, seen}, '0);
    end

    // R3/R4: one frame 0..9 must give -1,0..8 (never 0,-1,...)
    @(posedge clk); #1;
    for (int i = 0; i < FRAME_LEN; i++) sendWord(DATA_W'(i));
    waitDrain();
    check(expQ.size() == 0, "R3 first frame drained", DATA_W'(expQ.size()), '0);

    // R8: many frames with input gaps and output stalls
    bpMode = 1; gapMax = 3;
    for (int f = 0; f < 12; f++)
      for (int i = 0; i < FRAME_LEN; i++) sendWord($urandom);
    gapMax = 0;
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < FRAME_LEN; i++) sendWord(DATA_W'(32'h1000 + f * 16 + i));
    bpMode = 0; readyLevel = 1;
    waitDrain();
    check(expQ.size() == 0, "R8 stream drained", DATA_W'(expQ.size()), '0);

    // R5/R7: full FIFO with the drop position next
    readyLevel = 0;
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < FIFO_DEPTH; i++) sendWord(DATA_W'(32'hA0 + i));
    @(negedge clk);
    check(inReady == 0, "R7 full blocks input", {31'b0, inReady}, '0);
    @(posedge clk); #2 readyLevel = 1;
    @(posedge clk); #2 readyLevel = 0;
    @(posedge clk); #1;
    sendWord(32'hA8);
    @(negedge clk);
    check(inReady == 1, "R5 drop position ready while full", {31'b0, inReady}, 1);
    @(posedge clk); #1;
    sendWord(32'hA9);
    @(negedge clk);
    check(inReady == 0, "R7 full after drop", {31'b0, inReady}, '0);
    @(posedge clk); #1 readyLevel = 1;

    // R9: trailing placeholder appears with no new input
    waitDrain();
    check(expQ.size() == 0, "R9 placeholder without input", DATA_W'(expQ.size()), '0);
    @(negedge clk);
    check(outValid == 0, "R9 waits for data after placeholder", {31'b0, outValid}, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule